// File: doc/BRIEF.md
# Stereo Output Format Mixer

This block sits after the serial-audio deserializer of a digital-to-analog path. It takes one signed left sample and one signed right sample per sample period and decides what each of the two output channels carries. Each output can be silent, carry the left input, carry the right input, or carry the mono mix (L+R)/2. A 4-bit routing code selects these options, so sixteen output arrangements are possible. Normal stereo, swapped channels and full mono are among them.

A soft-mute control sits on top of the routing. When the mute bit is raised, a gain register falls by one step per sample until it reaches zero, so the audible level fades out instead of being cut off. When the bit is cleared, the gain climbs back at the same rate. Routing code, mute bit and inputs are all sampled with the sample strobe. Results appear on registered outputs together with an output strobe one clock later.

Top module: `stereo_fmt_mixer`

## Requirements
- R1: Bits [3:2] of `fmtCode` choose the content of `leftOut`, and bits [1:0] choose the content of `rightOut`.
- R2: A 2-bit selector value works as follows: 00 gives zero, 01 gives the right input, 10 gives the left input and 11 gives the mono mix.
- R3: Code 4'b1001 passes stereo straight through. Code 4'b0110 swaps the two channels. Code 4'b1111 puts the mono mix on both outputs.
- R4: The mono mix is floor((L+R)/2), computed one bit wider than the samples, so it cannot wrap even for full-scale inputs of equal sign.
- R5: On the clock edge where `sampleStb` is high, both outputs load their new values and `outStb` goes high for exactly that one following cycle. Without a strobe, `outStb` is low.
- R6: `fmtCode`, `muteReq` and the sample inputs have no effect between strobes. The outputs hold their last values until the next strobe.
- R7: At every strobe where `muteReq` is high, the gain g (range 0..256, where 256 is unity) falls by 1, with a floor at 0. The output is floor(routed * g / 256), using the gain after that strobe's step. After 256 consecutive muted strobes starting from unity, the output is exactly zero.
- R8: At every strobe where `muteReq` is low, the gain rises by 1, with a ceiling at 256. Starting from zero, 256 unmuted strobes restore the unity output.
- R9: After reset, both outputs are zero, `outStb` is low and the gain is at unity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | One-cycle pulse marking a new sample pair |
| leftIn | input | DATA_W | Signed left sample |
| rightIn | input | DATA_W | Signed right sample |
| fmtCode | input | 4 | Routing code: [3:2] selects the left output, [1:0] selects the right output |
| muteReq | input | 1 | Soft-mute request |
| leftOut | output | DATA_W | Signed left result |
| rightOut | output | DATA_W | Signed right result |
| outStb | output | 1 | Pulse marking new output values |

## Verification
Every result depends on the inputs of one strobe and is registered once. The bench therefore raises the strobe on a falling edge, lowers it on the next falling edge, and compares outputs and `outStb` at that point. Between strobes it changes the routing code and the mute bit, waits several idle cycles, and confirms that the outputs stayed unchanged and that `outStb` stayed low. The gain reference model is stepped once per strobe. Its expected output uses the gain after that step, so the sample where a ramp ends is checked exactly.

// File: rtl/fmtmix_pkg.sv
package fmtmix_pkg;
  // Selector encoding for one output channel
  typedef enum logic [1:0] {
    SEL_ZERO  = 2'b00,
    SEL_RIGHT = 2'b01,
    SEL_LEFT  = 2'b10,
    SEL_MONO  = 2'b11
  } chanSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new sample pair this cycle
    logic silent;  // post-step gain is zero
  } ctrlStrobes_t;
endpackage

// File: rtl/fmtmix_route.sv
module fmtmix_route #(
  parameter int DATA_W = 24
) (
  input  fmtmix_pkg::chanSel_e      sel,
  input  logic signed [DATA_W-1:0]  leftIn,
  input  logic signed [DATA_W-1:0]  rightIn,
  input  logic signed [DATA_W-1:0]  monoIn,
  output logic signed [DATA_W-1:0]  routed
);
  import fmtmix_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_RIGHT: routed = rightIn;
      SEL_LEFT:  routed = leftIn;
      SEL_MONO:  routed = monoIn;
      default:   routed = '0;
    endcase
  end
endmodule

// File: rtl/fmtmix_ctrl.sv
module fmtmix_ctrl #(
  parameter int RAMP_STEPS = 256,
  localparam int GAIN_W = $clog2(RAMP_STEPS) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleStb,
  input  logic                     muteReq,
  output fmtmix_pkg::ctrlStrobes_t ctrlOut,
  output logic [GAIN_W-1:0]        gainNext,
  output logic [GAIN_W-1:0]        gainQ
);
  localparam logic [GAIN_W-1:0] GAIN_FULL = GAIN_W'(RAMP_STEPS);

  always_comb begin
    if (muteReq)
      gainNext = (gainQ == '0) ? '0 : gainQ - 1'b1;
    else
      gainNext = (gainQ == GAIN_FULL) ? GAIN_FULL : gainQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gainQ <= GAIN_FULL;
    else if (sampleStb)
      gainQ <= gainNext;
  end

  assign ctrlOut.load   = sampleStb;
  assign ctrlOut.silent = (gainNext == '0);
endmodule

// File: rtl/fmtmix_datapath.sv
module fmtmix_datapath #(
  parameter int DATA_W     = 24,
  parameter int RAMP_STEPS = 256,
  localparam int GAIN_W    = $clog2(RAMP_STEPS) + 1,
  localparam int SHIFT     = $clog2(RAMP_STEPS),
  localparam int PROD_W    = DATA_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fmtmix_pkg::ctrlStrobes_t ctrlIn,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [3:0]               fmtCode,
  input  logic signed [DATA_W-1:0] leftIn,
  input  logic signed [DATA_W-1:0] rightIn,
  output logic signed [DATA_W-1:0] leftOut,
  output logic signed [DATA_W-1:0] rightOut,
  output logic                     outStb
);
  import fmtmix_pkg::*;

  // Mono mix with one guard bit, then arithmetic halving
  logic signed [DATA_W:0]   sumWide;
  logic signed [DATA_W-1:0] monoMix;
  assign sumWide = {leftIn[DATA_W-1], leftIn} + {rightIn[DATA_W-1], rightIn};
  assign monoMix = sumWide[DATA_W:1];

  logic signed [DATA_W-1:0] scaled [2];
  logic signed [GAIN_W:0]   gainSigned;
  assign gainSigned = $signed({1'b0, gain});

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    chanSel_e                 selCh;
    logic signed [DATA_W-1:0] routedCh;
    logic signed [PROD_W-1:0] prodCh;
    logic signed [PROD_W-1:0] shiftedCh;

    assign selCh = chanSel_e'(fmtCode[3-2*ch -: 2]);

    fmtmix_route #(.DATA_W(DATA_W)) u_route (
      .sel     (selCh),
      .leftIn  (leftIn),
      .rightIn (rightIn),
      .monoIn  (monoMix),
      .routed  (routedCh)
    );

    assign prodCh     = routedCh * gainSigned;
    assign shiftedCh  = prodCh >>> SHIFT;
    assign scaled[ch] = ctrlIn.silent ? '0 : shiftedCh[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftOut  <= '0;
      rightOut <= '0;
      outStb   <= 1'b0;
    end else begin
      outStb <= ctrlIn.load;
      if (ctrlIn.load) begin
        leftOut  <= scaled[0];
        rightOut <= scaled[1];
      end
    end
  end
endmodule

// File: rtl/stereo_fmt_mixer.sv
module stereo_fmt_mixer #(
  parameter int DATA_W     = 24,
  parameter int RAMP_STEPS = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleStb,
  input  logic signed [DATA_W-1:0] leftIn,
  input  logic signed [DATA_W-1:0] rightIn,
  input  logic [3:0]               fmtCode,
  input  logic                     muteReq,
  output logic signed [DATA_W-1:0] leftOut,
  output logic signed [DATA_W-1:0] rightOut,
  output logic                     outStb
);
  localparam int GAIN_W = $clog2(RAMP_STEPS) + 1;

  fmtmix_pkg::ctrlStrobes_t ctrlBus;
  logic [GAIN_W-1:0]        gainNext;
  logic [GAIN_W-1:0]        gainQ;

  fmtmix_ctrl #(.RAMP_STEPS(RAMP_STEPS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleStb (sampleStb),
    .muteReq   (muteReq),
    .ctrlOut   (ctrlBus),
    .gainNext  (gainNext),
    .gainQ     (gainQ)
  );

  fmtmix_datapath #(.DATA_W(DATA_W), .RAMP_STEPS(RAMP_STEPS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (ctrlBus),
    .gain     (gainNext),
    .fmtCode  (fmtCode),
    .leftIn   (leftIn),
    .rightIn  (rightIn),
    .leftOut  (leftOut),
    .rightOut (rightOut),
    .outStb   (outStb)
  );
endmodule

// File: rtl/fmtmix_chk.sv
module fmtmix_chk #(
  parameter int DATA_W     = 24,
  parameter int RAMP_STEPS = 256,
  localparam int GAIN_W    = $clog2(RAMP_STEPS) + 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleStb,
  input logic [3:0]               fmtCode,
  input logic signed [DATA_W-1:0] leftOut,
  input logic signed [DATA_W-1:0] rightOut,
  input logic                     outStb,
  input logic [GAIN_W-1:0]        gainQ
);
  localparam logic [GAIN_W:0] FULL_W = (GAIN_W+1)'(RAMP_STEPS);

  // R5
  out_stb_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> outStb);

  // R5
  out_stb_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> !outStb);

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> ($stable(leftOut) && $stable(rightOut)));

  // R2
  zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && fmtCode == 4'b0000) |=> (leftOut == '0 && rightOut == '0));

  // R3
  mono_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && fmtCode == 4'b1111) |=> (leftOut == rightOut));

  // R7
  gain_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> (({1'b0, gainQ} <= {1'b0, $past(gainQ)} + 1'b1) &&
                   ({1'b0, gainQ} + 1'b1 >= {1'b0, $past(gainQ)})));

  // R8
  gain_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, gainQ} <= FULL_W);
endmodule

bind stereo_fmt_mixer fmtmix_chk #(.DATA_W(DATA_W), .RAMP_STEPS(RAMP_STEPS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sampleStb (sampleStb),
  .fmtCode   (fmtCode),
  .leftOut   (leftOut),
  .rightOut  (rightOut),
  .outStb    (outStb),
  .gainQ     (gainQ)
);

// File: tb/sim_stereo_fmt_mixer.sv
module sim_stereo_fmt_mixer;
  localparam int DW = 24;
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DW-1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0;
  logic signed [DW-1:0] leftIn = '0, rightIn = '0;
  logic [3:0] fmtCode = 4'b1001;
  logic muteReq = 1'b0;
  logic signed [DW-1:0] leftOut, rightOut;
  logic outStb;

  int checks = 0;
  int failures = 0;
  int gModel = 256;
  longint expL, expR;

  always #2.5 clk = ~clk;

  stereo_fmt_mixer #(.DATA_W(DW), .RAMP_STEPS(256)) u0 (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .leftIn(leftIn),
    .rightIn(rightIn), .fmtCode(fmtCode), .muteReq(muteReq),
    .leftOut(leftOut), .rightOut(rightOut), .outStb(outStb)
  );

  function automatic longint routeOf(input logic [1:0] sel, input longint l, input longint r);
    case (sel)
      2'b00: return 0;
      2'b01: return r;
      2'b10: return l;
      default: return (l + r) >>> 1;
    endcase
  endfunction

  function automatic longint scaleOf(input longint x, input int g);
    return (x * longint'(g)) >>> 8;
  endfunction

  function automatic longint rndSample();
    logic [DW-1:0] raw;
    raw = DW'($urandom);
    return longint'($signed(raw));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge, sample at the next falling edge
  task automatic doSample(input longint l, input longint r, input logic [3:0] code,
                          input logic mute, input string req);
    leftIn = DW'(l);
    rightIn = DW'(r);
    fmtCode = code;
    muteReq = mute;
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    if (mute) gModel = (gModel == 0) ? 0 : gModel - 1;
    else      gModel = (gModel == 256) ? 256 : gModel + 1;
    expL = scaleOf(routeOf(code[3:2], l, r), gModel);
    expR = scaleOf(routeOf(code[1:0], l, r), gModel);
    chk(longint'(leftOut) == expL, req, "leftOut", longint'(leftOut), expL);
    chk(longint'(rightOut) == expR, req, "rightOut", longint'(rightOut), expR);
    chk(outStb == 1'b1, "R5", "outStb pulse", longint'(outStb), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint heldL, heldR;
    logic muteR;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(leftOut == '0, "R9", "leftOut in reset", longint'(leftOut), 0);
    chk(rightOut == '0, "R9", "rightOut in reset", longint'(rightOut), 0);
    chk(outStb == 1'b0, "R9", "outStb in reset", longint'(outStb), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9 unity gain straight after reset, R3 named codes
    doSample(1234567, -7654321, 4'b1001, 1'b0, "R9");
    doSample(1234567, -7654321, 4'b1001, 1'b0, "R3");
    doSample(1234567, -7654321, 4'b0110, 1'b0, "R3");
    doSample(1234567, -7654321, 4'b1111, 1'b0, "R3");
    // R4 mono mix at extremes and odd sums
    doSample(MAXV, MAXV, 4'b1111, 1'b0, "R4");
    doSample(MINV, MINV, 4'b1111, 1'b0, "R4");
    doSample(MAXV, MINV, 4'b1111, 1'b0, "R4");
    doSample(-3, 0, 4'b1111, 1'b0, "R4");
    // R1 R2 every code
    for (int c = 0; c < 16; c++)
      doSample(rndSample(), rndSample(), 4'(c), 1'b0, "R1");
    for (int c = 0; c < 16; c++)
      doSample(rndSample(), rndSample(), 4'(c), 1'b0, "R2");

    // R5 R6 no effect between strobes
    heldL = longint'(leftOut);
    heldR = longint'(rightOut);
    fmtCode = 4'b0000;
    muteReq = 1'b1;
    leftIn = DW'(MINV);
    repeat (4) @(negedge clk);
    chk(longint'(leftOut) == heldL, "R6", "leftOut held", longint'(leftOut), heldL);
    chk(longint'(rightOut) == heldR, "R6", "rightOut held", longint'(rightOut), heldR);
    chk(outStb == 1'b0, "R5", "outStb idle", longint'(outStb), 0);

    // R7 ramp down over 256 strobes
    for (int i = 0; i < 256; i++) begin
      doSample(MAXV, MINV, 4'b1001, 1'b1, "R7");
      if (i == 254)
        chk(leftOut != '0, "R7", "nonzero before last step", longint'(leftOut), 1);
    end
    chk(leftOut == '0, "R7", "silent after 256", longint'(leftOut), 0);
    chk(rightOut == '0, "R7", "silent after 256", longint'(rightOut), 0);
    doSample(MAXV, MINV, 4'b1001, 1'b1, "R7");
    // R8 ramp back up
    for (int i = 0; i < 256; i++)
      doSample(MAXV, MINV, 4'b1001, 1'b0, "R8");
    chk(longint'(leftOut) == MAXV, "R8", "unity restored", longint'(leftOut), MAXV);
    chk(longint'(rightOut) == MINV, "R8", "unity restored", longint'(rightOut), MINV);
    doSample(MAXV, MINV, 4'b1001, 1'b0, "R8");

    // Random mix with occasional mute toggles and idle gaps
    muteR = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (($urandom % 64) == 0) muteR = ~muteR;
      doSample(rndSample(), rndSample(), 4'($urandom), muteR, "R7");
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule